// File: doc/BRIEF.md
# Lowest-Priority Interrupt Redirection Router

This block chooses exactly one destination CPU for each interrupt request in a small multiprocessor with up to eight CPUs. A route table has one entry per interrupt line. Each entry holds a target CPU and a mode flag. In fixed mode the request always goes to the stored target. In redirectable mode the router compares the priority hints that each CPU presents and sends the request to the CPU whose hint is lowest. The comparison starts at the entry's target and wraps around, so on a tie the target wins, and after it the CPUs that follow it in index order.

Software programs entries through a single-cycle write port. A write carries a CPU mask, and the mask is reduced to its lowest set bit. The same port reads an entry back as a one-hot mask plus its mode. A strap input, sampled while reset is held, decides how the table starts. With redirection enabled, every line starts redirectable toward CPU 0. With redirection disabled, the lines are dealt across the CPUs in round-robin order and routing is fixed. A routing decision takes two registered stages. While a decision is in flight, the request port is not ready.

Top module: `irq_redir_router`

## Requirements
- R1: When reset is released with `redir_strap`=1, every entry reads back as target mask 0x01 (CPU 0) with mode 1 (redirectable), and `cfg_err`=0.
- R2: When reset is released with `redir_strap`=0, entry i reads back as target CPU (i mod N_CPU) with mode 0 (fixed).
- R3: A write with a non-zero mask stores only the least significant set bit as the target and stores `cfg_wmode` as the mode. Readback returns the target as a one-hot mask.
- R4: A write with an all-zero mask changes nothing in the addressed entry, neither target nor mode. It sets `cfg_err`, which stays at 1 until the next reset.
- R5: In fixed mode (mode 0), the request is delivered to the stored target whatever the hints are.
- R6: In redirectable mode, the request is delivered to the CPU with the numerically lowest 2-bit hint. The hint codes are 00 idle, 01 busy and 11 going offline, and CPU c's hint sits in `hint[2c+1:2c]`. Ties go to the first CPU reached when scanning upward from the target, wrapping past the highest CPU.
- R7: In redirectable mode, a CPU whose hint is 11 is never chosen while any other CPU has a lower hint. If every hint is 11, the stored target is chosen.
- R8: When `redir_strap` was 0 at reset, every entry routes as fixed, even when its mode bit has been written to 1.
- R9: A request accepted at a clock edge (`irq_req` and `irq_ready` both 1) uses the hints present at that edge. `dlv_valid` is then high for exactly one cycle, starting after the second edge that follows.
- R10: `irq_ready` is 0 in the cycle after a request is accepted, and also while reset is held. The block therefore accepts at most one request every two cycles.
- R11: While `dlv_valid` is 1, `dlv_cpu` is one-hot. While `dlv_valid` is 0, `dlv_cpu` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redir_strap | input | 1 | Global redirection enable, sampled while reset is low |
| cfg_we | input | 1 | Route entry write strobe |
| cfg_addr | input | LINE_W | Entry index for write and readback |
| cfg_wmask | input | N_CPU | CPU mask to write |
| cfg_wmode | input | 1 | Mode to write: 0 fixed, 1 redirectable |
| cfg_rmask | output | N_CPU | One-hot target of the addressed entry |
| cfg_rmode | output | 1 | Mode of the addressed entry |
| cfg_err | output | 1 | Sticky flag set by a zero-mask write |
| hint | input | N_CPU*2 | Per-CPU priority hints, 2 bits each |
| irq_req | input | 1 | Interrupt request |
| irq_line | input | LINE_W | Interrupt line of the request |
| irq_ready | output | 1 | Request can be accepted this cycle |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_cpu | output | N_CPU | One-hot chosen CPU |

## Verification
On every cycle the assertions check the delivery timing and its shape: the two-edge latency, the single-cycle strobe, ready dropping after an accept, and a one-hot or zero delivery vector. They also check that a zero-mask write raises the error flag and that the flag stays set, and that readback is always one-hot. Only the bench scenarios can show which CPU wins: the minimum search, the wrapped tie-break, exclusion of offline CPUs, fixed routing that ignores hints, the two reset layouts of the table, and the strap forcing fixed routing.

// File: rtl/irq_redir_router.sv
module irq_redir_router #(
  parameter int N_CPU  = 8,
  parameter int N_LINE = 16,
  parameter int HINT_W = 2,
  localparam int CPU_W  = $clog2(N_CPU),
  localparam int LINE_W = $clog2(N_LINE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     redir_strap,
  input  logic                     cfg_we,
  input  logic [LINE_W-1:0]        cfg_addr,
  input  logic [N_CPU-1:0]         cfg_wmask,
  input  logic                     cfg_wmode,
  output logic [N_CPU-1:0]         cfg_rmask,
  output logic                     cfg_rmode,
  output logic                     cfg_err,
  input  logic [N_CPU*HINT_W-1:0]  hint,
  input  logic                     irq_req,
  input  logic [LINE_W-1:0]        irq_line,
  output logic                     irq_ready,
  output logic                     dlv_valid,
  output logic [N_CPU-1:0]         dlv_cpu
);

  logic [CPU_W-1:0]        tgt_q [N_LINE];
  logic [N_LINE-1:0]       mode_q;
  logic                    redir_q;
  logic                    err_q;

  logic                    s1_vld;
  logic [CPU_W-1:0]        s1_tgt;
  logic                    s1_redir;
  logic [N_CPU*HINT_W-1:0] s1_hint;

  logic [CPU_W-1:0]        pick;
  logic [HINT_W-1:0]       pick_h;
  logic [CPU_W-1:0]        sel;
  logic                    accept;
  logic                    wr_ok;

  function automatic logic [CPU_W-1:0] low_idx(input logic [N_CPU-1:0] m);
    logic [CPU_W-1:0] r;
    r = '0;
    for (int i = N_CPU - 1; i >= 0; i--)
      if (m[i]) r = CPU_W'(i);
    return r;
  endfunction

  assign accept    = irq_req && irq_ready;
  assign wr_ok     = cfg_we && (cfg_wmask != '0);
  assign irq_ready = rst_n && !s1_vld;
  assign cfg_err   = err_q;
  assign cfg_rmask = N_CPU'(1) << tgt_q[cfg_addr];
  assign cfg_rmode = mode_q[cfg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_q <= redir_strap;
      err_q   <= 1'b0;
      for (int i = 0; i < N_LINE; i++) begin
        tgt_q[i]  <= redir_strap ? '0 : CPU_W'(i % N_CPU);
        mode_q[i] <= redir_strap;
      end
    end else begin
      if (cfg_we && cfg_wmask == '0) err_q <= 1'b1;
      if (wr_ok) begin
        tgt_q[cfg_addr]  <= low_idx(cfg_wmask);
        mode_q[cfg_addr] <= cfg_wmode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_tgt   <= tgt_q[irq_line];
      s1_redir <= mode_q[irq_line] && redir_q;
      s1_hint  <= hint;
    end
  end

  always_comb begin
    pick   = s1_tgt;
    pick_h = s1_hint[s1_tgt*HINT_W +: HINT_W];
    for (int k = 1; k < N_CPU; k++) begin
      if (s1_hint[((int'(s1_tgt) + k) % N_CPU)*HINT_W +: HINT_W] < pick_h) begin
        pick   = CPU_W'((int'(s1_tgt) + k) % N_CPU);
        pick_h = s1_hint[((int'(s1_tgt) + k) % N_CPU)*HINT_W +: HINT_W];
      end
    end
  end

  assign sel = s1_redir ? pick : s1_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid <= 1'b0;
      dlv_cpu   <= '0;
    end else begin
      dlv_valid <= s1_vld;
      dlv_cpu   <= s1_vld ? (N_CPU'(1) << sel) : '0;
    end
  end

endmodule

// File: rtl/irq_redir_router_chk.sv
module irq_redir_router_chk #(
  parameter int N_CPU  = 8,
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [N_CPU-1:0]  cfg_wmask,
  input logic [N_CPU-1:0]  cfg_rmask,
  input logic              cfg_err,
  input logic              irq_req,
  input logic              irq_ready,
  input logic              dlv_valid,
  input logic [N_CPU-1:0]  dlv_cpu
);

  AST_DLV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $onehot(dlv_cpu)); // R11
  AST_DLV_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid |-> dlv_cpu == '0); // R11
  AST_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ready) |=> ##1 dlv_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $past(irq_req && irq_ready, 2)); // R9
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> !dlv_valid); // R9
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ready) |=> !irq_ready); // R10
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wmask == '0) |=> cfg_err); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R4
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cfg_rmask)); // R3

endmodule

bind irq_redir_router irq_redir_router_chk #(.N_CPU(N_CPU), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wmask(cfg_wmask),
  .cfg_rmask(cfg_rmask), .cfg_err(cfg_err), .irq_req(irq_req),
  .irq_ready(irq_ready), .dlv_valid(dlv_valid), .dlv_cpu(dlv_cpu)
);

// File: tb/sim_irq_redir_router.sv
module sim_irq_redir_router;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redir_strap = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [NC-1:0] cfg_wmask = '0;
  logic cfg_wmode = 1'b0;
  logic [NC-1:0] cfg_rmask;
  logic cfg_rmode;
  logic cfg_err;
  logic [2*NC-1:0] hint = '0;
  logic irq_req = 1'b0;
  logic [3:0] irq_line = '0;
  logic irq_ready;
  logic dlv_valid;
  logic [NC-1:0] dlv_cpu;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redir_router u0 (
    .clk(clk), .rst_n(rst_n), .redir_strap(redir_strap),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wmask(cfg_wmask),
    .cfg_wmode(cfg_wmode), .cfg_rmask(cfg_rmask), .cfg_rmode(cfg_rmode),
    .cfg_err(cfg_err), .hint(hint), .irq_req(irq_req), .irq_line(irq_line),
    .irq_ready(irq_ready), .dlv_valid(dlv_valid), .dlv_cpu(dlv_cpu)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] hset(input logic [15:0] base, input int cpu, input logic [1:0] v);
    logic [15:0] r;
    r = base;
    r[cpu*2 +: 2] = v;
    return r;
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    redir_strap = strap;
    irq_req = 1'b0;
    cfg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 ready in reset", 32'(irq_ready), 32'd0);
    rst_n = 1'b1;
    redir_strap = ~strap;
  endtask

  task automatic write_entry(input int line, input logic [NC-1:0] m, input logic md);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 4'(line);
    cfg_wmask = m;
    cfg_wmode = md;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_entry(input string rq, input int line, input logic [NC-1:0] em, input logic emd);
    cfg_addr = 4'(line);
    #1;
    check({rq, " mask"}, 32'(cfg_rmask), 32'(em));
    check({rq, " mode"}, 32'(cfg_rmode), 32'(emd));
  endtask

  task automatic send(input string rq, input int line, input logic [15:0] h, input int exp_cpu);
    @(negedge clk);
    check("R10 ready before request", 32'(irq_ready), 32'd1);
    irq_req = 1'b1;
    irq_line = 4'(line);
    hint = h;
    @(negedge clk);
    irq_req = 1'b0;
    hint = ~h;
    check("R10 ready low after accept", 32'(irq_ready), 32'd0);
    check("R9 no early delivery", 32'(dlv_valid), 32'd0);
    @(negedge clk);
    check("R9 delivery after two edges", 32'(dlv_valid), 32'd1);
    check(rq, 32'(dlv_cpu), 32'(8'(1) << exp_cpu));
    @(negedge clk);
    check("R9 single cycle strobe", 32'(dlv_valid), 32'd0);
    check("R11 idle vector zero", 32'(dlv_cpu), 32'd0);
  endtask

  task automatic t_reset_redir();
    do_reset(1'b1);
    for (int i = 0; i < NL; i++) read_entry("R1 reset entry", i, 8'h01, 1'b1);
    check("R1 err clear", 32'(cfg_err), 32'd0);
    check("R11 no delivery after reset", 32'(dlv_valid), 32'd0);
  endtask

  task automatic t_reset_fixed();
    do_reset(1'b0);
    for (int i = 0; i < NL; i++) read_entry("R2 round robin entry", i, 8'(1) << (i % NC), 1'b0);
  endtask

  task automatic t_mask_reduce();
    do_reset(1'b1);
    write_entry(7, 8'b1011_0100, 1'b0);
    read_entry("R3 multi bit mask", 7, 8'h04, 1'b0);
    write_entry(9, 8'h80, 1'b1);
    read_entry("R3 top bit mask", 9, 8'h80, 1'b1);
    read_entry("R3 neighbour untouched", 8, 8'h01, 1'b1);
  endtask

  task automatic t_zero_mask();
    do_reset(1'b1);
    write_entry(5, 8'h10, 1'b0);
    check("R4 err before zero write", 32'(cfg_err), 32'd0);
    write_entry(5, 8'h00, 1'b1);
    read_entry("R4 zero write ignored", 5, 8'h10, 1'b0);
    check("R4 err set", 32'(cfg_err), 32'd1);
    write_entry(5, 8'h02, 1'b1);
    read_entry("R4 later write applies", 5, 8'h02, 1'b1);
    check("R4 err sticky", 32'(cfg_err), 32'd1);
  endtask

  task automatic t_fixed();
    do_reset(1'b1);
    write_entry(2, 8'h40, 1'b0);
    send("R5 fixed ignores hints", 2, hset(16'h0000, 6, 2'b11), 6);
    send("R5 fixed with idle elsewhere", 2, hset(16'h5555, 1, 2'b00), 6);
  endtask

  task automatic t_redir();
    do_reset(1'b1);
    send("R6 lowest hint wins", 0, hset(16'h5555, 3, 2'b00), 3);
    write_entry(4, 8'h20, 1'b1);
    send("R6 tie scan wraps from target", 4, hset(hset(16'h5555, 2, 2'b00), 7, 2'b00), 7);
    write_entry(6, 8'h10, 1'b1);
    send("R6 tie keeps target", 6, 16'h0000, 4);
    write_entry(3, 8'h80, 1'b1);
    send("R6 wrap past highest", 3, hset(hset(16'h5555, 1, 2'b00), 5, 2'b00), 1);
  endtask

  task automatic t_max();
    do_reset(1'b1);
    write_entry(1, 8'h04, 1'b1);
    send("R7 offline skipped", 1, hset(16'hFFFF, 0, 2'b01), 0);
    send("R7 all offline uses target", 1, 16'hFFFF, 2);
  endtask

  task automatic t_strap_fixed();
    do_reset(1'b0);
    write_entry(3, 8'h02, 1'b1);
    read_entry("R8 mode bit stored", 3, 8'h02, 1'b1);
    send("R8 strap forces fixed", 3, hset(16'h0000, 1, 2'b11), 1);
    send("R8 round robin line", 13, hset(16'h0000, 5, 2'b11), 5);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset_redir();
    t_reset_fixed();
    t_mask_reduce();
    t_zero_mask();
    t_fixed();
    t_redir();
    t_max();
    t_strap_fixed();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule